// File: doc/BRIEF.md
# Programmable Down-Counting Divider With Falling-Edge Flag

This block is a 16-bit programmable divider built around a down-counter. Its divisor is held in two byte-wide preload registers: a high byte and a low byte. A single-cycle count-enable tick, taken from whatever clock source the surrounding logic selects, advances the count. The divider has two modes. In square mode the output is a symmetric square wave whose half period is the divisor in ticks, which makes it usable as a 16x baud clock. In one-shot mode the output falls once, after the divisor's worth of ticks, and then holds.

A start strobe copies the preload pair into the counter, drives the output high and begins counting. A stop strobe only clears the flag. The flag is a status bit that is set on every high-to-low transition of the output. Both strobes are single-cycle pulses decoded by the host from two reserved read addresses. No data value goes with either strobe.

All registers update on the rising clock edge. The reset is synchronous and active high.

Top module: `ctmr_top`

## Requirements
- R1: While reset is high, and in the first cycle after it is released, the output is 1, the flag is 0, counting is idle and both preload bytes are 0.
- R2: A write with `pre_sel`=0 loads the low byte and one with `pre_sel`=1 loads the high byte. The divisor is {high, low}. A write becomes visible to loads from the next cycle onward.
- R3: In square mode (`mode_square`=1) the output inverts at the edge that samples the divisor-th tick counted since the last start or inversion. At each inversion the counter reloads from the current preload pair.
- R4: The flag becomes 1 at the same clock edge where the output goes from 1 to 0. It never becomes 1 at any other time.
- R5: A stop strobe clears the flag at the next edge, unless R11 applies.
- R6: A stop strobe has no effect on counting or on the output in either mode.
- R7: In one-shot mode (`mode_square`=0) the output goes to 0 at the edge that samples the divisor-th tick. Counting then halts, and the output stays at 0 until the next start.
- R8: A divisor of 0 counts as 65536 ticks.
- R9: The counter and the output change only at edges where `cnt_tick`=1, or where a start is present.
- R10: A start loads the preload pair into the counter, sets the output to 1 and begins counting. When a start and a tick arrive in the same cycle, the start wins and the tick is not counted.
- R11: When a falling output edge and a stop strobe fall in the same cycle, the flag ends that cycle set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_tick | input | 1 | Count enable from the selected clock source |
| mode_square | input | 1 | 1 = square mode, 0 = one-shot mode |
| pre_wr | input | 1 | Preload byte write strobe |
| pre_sel | input | 1 | Byte select: 0 = low byte, 1 = high byte |
| pre_data | input | 8 | Preload byte value |
| cmd_start | input | 1 | Start strobe |
| cmd_stop | input | 1 | Stop strobe (clears the flag) |
| ct_out | output | 1 | Divider output |
| ct_ready | output | 1 | Falling-edge flag |

## Verification
Two situations are hard to reach from the ports. The first is the zero-divisor case, which can only be seen by letting a one-shot run through all 65536 ticks with the enable held high. The bench does exactly that and watches for the single fall at the end. The second is a stop strobe landing on the exact cycle of a falling edge. To cover it, the bench holds stop high across several short square-wave periods, so that every fall coincides with a stop. A behavioural model then checks both output and flag on every cycle.

// File: rtl/ctmr_pkg.sv
package ctmr_pkg;

    localparam int CT_BYTE_W  = 8;
    localparam int CT_LANES   = 2;
    localparam int CT_DIV_W   = CT_BYTE_W * CT_LANES;
    localparam int CT_CNT_W   = CT_DIV_W + 1;

    typedef enum logic {
        CT_MODE_ONESHOT = 1'b0,
        CT_MODE_SQUARE  = 1'b1
    } ct_mode_e;

    typedef struct packed {
        logic [CT_BYTE_W-1:0] hi;
        logic [CT_BYTE_W-1:0] lo;
    } ct_div_t;

    typedef struct packed {
        logic                run;
        logic                level;
        logic [CT_CNT_W-1:0] cnt;
    } ct_state_t;

    // Divisor to load value; zero means a full 2**CT_DIV_W ticks.
    function automatic logic [CT_CNT_W-1:0] ct_load(ct_div_t d);
        logic [CT_DIV_W-1:0] v;
        v = {d.hi, d.lo};
        if (v == '0) return {1'b1, {CT_DIV_W{1'b0}}};
        return {1'b0, v};
    endfunction

endpackage

// File: rtl/ctmr_preload.sv
module ctmr_preload
    import ctmr_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic                 wr_sel,
    input  logic [CT_BYTE_W-1:0] wr_data,
    output ct_div_t              div
);

    logic [CT_LANES-1:0][CT_BYTE_W-1:0] lane_q;

    for (genvar g = 0; g < CT_LANES; g++) begin : g_lane
        always_ff @(posedge clk) begin
            if (rst)
                lane_q[g] <= '0;
            else if (wr_en && (int'(wr_sel) == g))
                lane_q[g] <= wr_data;
        end
    end

    assign div.hi = lane_q[1];
    assign div.lo = lane_q[0];

endmodule

// File: rtl/ctmr_core.sv
module ctmr_core
    import ctmr_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     tick,
    input  ct_mode_e mode,
    input  logic     start,
    input  ct_div_t  div,
    output logic     level,
    output logic     fall_evt
);

    ct_state_t cur_q, nxt;

    always_comb begin
        nxt = cur_q;
        if (start) begin
            nxt.cnt   = ct_load(div);
            nxt.run   = 1'b1;
            nxt.level = 1'b1;
        end else if (cur_q.run && tick) begin
            if (cur_q.cnt == CT_CNT_W'(1)) begin
                if (mode == CT_MODE_SQUARE) begin
                    nxt.level = ~cur_q.level;
                    nxt.cnt   = ct_load(div);
                end else begin
                    nxt.level = 1'b0;
                    nxt.run   = 1'b0;
                    nxt.cnt   = '0;
                end
            end else begin
                nxt.cnt = cur_q.cnt - CT_CNT_W'(1);
            end
        end
        fall_evt = cur_q.level & ~nxt.level;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q.run   <= 1'b0;
            cur_q.level <= 1'b1;
            cur_q.cnt   <= '0;
        end else begin
            cur_q <= nxt;
        end
    end

    assign level = cur_q.level;

    AST_START_HIGH: assert property (@(posedge clk) disable iff (rst)
        start |=> level);                                              // R10
    AST_ONESHOT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (mode == CT_MODE_ONESHOT && !level && !start) |=> !level);     // R7
    AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (rst)
        (!tick && !start) |=> $stable(level));                         // R9

endmodule

// File: rtl/ctmr_flag.sv
module ctmr_flag (
    input  logic clk,
    input  logic rst,
    input  logic fall_evt,
    input  logic stop,
    input  logic level,
    output logic ready
);

    always_ff @(posedge clk) begin
        if (rst)
            ready <= 1'b0;
        else if (fall_evt)
            ready <= 1'b1;
        else if (stop)
            ready <= 1'b0;
    end

    AST_READY_ON_FALL: assert property (@(posedge clk) disable iff (rst)
        $rose(ready) |-> $fell(level));                                // R4
    AST_STOP_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (stop && !fall_evt) |=> !ready);                               // R5
    AST_STOP_LOSES: assert property (@(posedge clk) disable iff (rst)
        (stop && fall_evt) |=> ready);                                 // R11

endmodule

// File: rtl/ctmr_top.sv
module ctmr_top
    import ctmr_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cnt_tick,
    input  logic                 mode_square,
    input  logic                 pre_wr,
    input  logic                 pre_sel,
    input  logic [CT_BYTE_W-1:0] pre_data,
    input  logic                 cmd_start,
    input  logic                 cmd_stop,
    output logic                 ct_out,
    output logic                 ct_ready
);

    ct_div_t  div;
    ct_mode_e mode;
    logic     fall_evt;

    assign mode = mode_square ? CT_MODE_SQUARE : CT_MODE_ONESHOT;

    ctmr_preload i_preload (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (pre_wr),
        .wr_sel  (pre_sel),
        .wr_data (pre_data),
        .div     (div)
    );

    ctmr_core i_core (
        .clk      (clk),
        .rst      (rst),
        .tick     (cnt_tick),
        .mode     (mode),
        .start    (cmd_start),
        .div      (div),
        .level    (ct_out),
        .fall_evt (fall_evt)
    );

    ctmr_flag i_flag (
        .clk      (clk),
        .rst      (rst),
        .fall_evt (fall_evt),
        .stop     (cmd_stop),
        .level    (ct_out),
        .ready    (ct_ready)
    );

endmodule

// File: tb/test_ctmr_top.sv
module test_ctmr_top;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cnt_tick = 1'b0;
    logic       mode_square = 1'b0;
    logic       pre_wr = 1'b0;
    logic       pre_sel = 1'b0;
    logic [7:0] pre_data = 8'h00;
    logic       cmd_start = 1'b0;
    logic       cmd_stop = 1'b0;
    logic       ct_out;
    logic       ct_ready;

    int    checks = 0;
    int    errors = 0;
    string cur_req = "R1";

    // behavioural reference state
    int m_lo = 0, m_hi = 0, m_cnt = 0;
    bit m_run = 0, m_out = 1, m_rdy = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ctmr_top i_ctmr_top (
        .clk(clk), .rst(rst), .cnt_tick(cnt_tick), .mode_square(mode_square),
        .pre_wr(pre_wr), .pre_sel(pre_sel), .pre_data(pre_data),
        .cmd_start(cmd_start), .cmd_stop(cmd_stop),
        .ct_out(ct_out), .ct_ready(ct_ready)
    );

    always @(posedge clk) begin
        int  dv;
        bit  prev;
        if (rst) begin
            m_lo = 0; m_hi = 0; m_cnt = 0; m_run = 0; m_out = 1; m_rdy = 0;
        end else begin
            dv = m_hi * 256 + m_lo;
            if (dv == 0) dv = 65536;
            prev = m_out;
            if (cmd_start) begin
                m_cnt = dv; m_run = 1; m_out = 1;
            end else if (m_run && cnt_tick) begin
                if (m_cnt == 1) begin
                    if (mode_square) begin m_out = !m_out; m_cnt = dv; end
                    else begin m_out = 0; m_run = 0; end
                end else m_cnt = m_cnt - 1;
            end
            if (prev && !m_out) m_rdy = 1;
            else if (cmd_stop) m_rdy = 0;
            if (pre_wr) begin
                if (pre_sel) m_hi = pre_data; else m_lo = pre_data;
            end
        end
    end

    task automatic check_bit(string req, string what, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%b expected=%b at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic step();
        @(negedge clk);
        check_bit(cur_req, "ct_out", ct_out, m_out);
        check_bit(cur_req, "ct_ready", ct_ready, m_rdy);
    endtask

    task automatic steps(int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic write_byte(logic sel, logic [7:0] d);
        pre_wr = 1'b1; pre_sel = sel; pre_data = d;
        step();
        pre_wr = 1'b0;
    endtask

    task automatic pulse_start();
        cmd_start = 1'b1;
        step();
        cmd_start = 1'b0;
    endtask

    initial begin
        // R1: reset state
        steps(3);
        rst = 1'b0;
        step();
        check_bit("R1", "out after reset", ct_out, 1'b1);
        check_bit("R1", "ready after reset", ct_ready, 1'b0);

        // R3 R4: square wave, divisor 3, tick every cycle
        cur_req = "R3";
        write_byte(1'b0, 8'd3);
        mode_square = 1'b1; cnt_tick = 1'b1;
        pulse_start();
        steps(3);
        check_bit("R3", "out low after 3 ticks", ct_out, 1'b0);
        check_bit("R4", "ready set on fall", ct_ready, 1'b1);
        cur_req = "R4";
        steps(20);

        // R5 R6: stop clears flag, toggling carries on
        cur_req = "R5";
        cmd_stop = 1'b1; step(); cmd_stop = 1'b0;
        cur_req = "R6";
        steps(20);

        // R11: stop held across several falls, divisor 2
        cur_req = "R11";
        write_byte(1'b0, 8'd2);
        pulse_start();
        cmd_stop = 1'b1;
        steps(13);
        cmd_stop = 1'b0;
        steps(4);

        // R9: gated ticks double the half period
        cur_req = "R9";
        write_byte(1'b0, 8'd4);
        pulse_start();
        for (int i = 0; i < 40; i++) begin
            cnt_tick = ~cnt_tick;
            step();
        end
        cnt_tick = 1'b0;
        steps(12);
        cnt_tick = 1'b1;

        // R2: upper byte participates, divisor 0x0102
        cur_req = "R2";
        write_byte(1'b1, 8'h01);
        write_byte(1'b0, 8'h02);
        pulse_start();
        steps(258);
        check_bit("R2", "out low after 258 ticks", ct_out, 1'b0);
        steps(300);

        // R7: one-shot, divisor 5, halts low
        cur_req = "R7";
        write_byte(1'b1, 8'h00);
        write_byte(1'b0, 8'd5);
        mode_square = 1'b0;
        pulse_start();
        steps(4);
        check_bit("R7", "out high before terminal", ct_out, 1'b1);
        step();
        check_bit("R7", "out low at terminal", ct_out, 1'b0);
        steps(30);
        check_bit("R7", "out held low", ct_out, 1'b0);
        cmd_stop = 1'b1; step(); cmd_stop = 1'b0;
        steps(5);

        // R10: restart mid-count with start colliding with tick
        cur_req = "R10";
        pulse_start();
        steps(2);
        pulse_start();
        check_bit("R10", "out high after restart", ct_out, 1'b1);
        steps(10);

        // R8: zero divisor counts 65536 ticks
        cur_req = "R8";
        write_byte(1'b0, 8'd0);
        pulse_start();
        steps(65535);
        check_bit("R8", "out high at 65535 ticks", ct_out, 1'b1);
        step();
        check_bit("R8", "out low at 65536 ticks", ct_out, 1'b0);
        check_bit("R8", "ready at 65536 ticks", ct_ready, 1'b1);
        steps(5);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule